// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block hands out one memory address per access for a processor datapath. It keeps four pointer registers, four step registers and four span registers, each span belonging to one pointer. An access names one pointer and one step register. The current pointer value is presented as the address on the following cycle, and the pointer itself advances by the selected step in the same edge.

A span of zero gives plain linear stepping that wraps at the top of the address space. A nonzero span confines the pointer to a circular window. The window starts at the pointer rounded down to a multiple of the smallest power of two that is at least the span. Steps are two's complement, so buffers can be walked either way. A per-access flag mirrors the emitted address bit for bit, which gives the scrambled ordering used by radix-2 FFT passes. All twelve registers are loaded through a single write port.

Top module: `cbuf_agen`

## Requirements
- R1: After reset every pointer, step and span register is zero, `addr_out` is zero and `addr_vld` is low.
- R2: When `acc_en` is high at a clock edge, `addr_vld` is high after that edge and `addr_out` holds the value the selected pointer had before the edge.
- R3: With span zero the pointer becomes (pointer + step) modulo 2^AW, where the step is read as an AW-bit two's complement value.
- R4: An access changes only the pointer named by `acc_ptr`, using the step register named by `acc_mod`; the other pointers keep their values.
- R5: With nonzero span L and a non-negative step of at most L, a result at or above base+L is pulled back by L. The base is the pointer with its low bits cleared up to the smallest power of two at or above L. This also holds at the very top of the address space.
- R6: With nonzero span L and a negative step of magnitude at most L, a result below the base is raised by L.
- R7: When `brev_en` is high with an access, `addr_out` is the pointer with bit i moved to bit AW-1-i; the stored pointer still advances normally.
- R8: When a pointer write and an access to the same pointer fall in one cycle, the written value is stored and the step is discarded; the address output still shows the value from before the edge.
- R9: `wr_sel` selects the register class: 0 pointer, 1 step, 2 span; code 3 writes nothing.
- R10: Without an access `addr_vld` is low, `addr_out` keeps its last value, and no pointer changes unless written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register class: 0 pointer, 1 step, 2 span, 3 none |
| wr_idx | input | 2 | Register number within the class |
| wr_data | input | 14 | Value to write |
| acc_en | input | 1 | Access strobe |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_mod | input | 2 | Step register used by the access |
| brev_en | input | 1 | Emit the address bit-reversed |
| addr_out | output | 14 | Address of the last access |
| addr_vld | output | 1 | High for one cycle after each access |

## Verification
The bench sweeps every span from 1 to 12, every start offset inside the window and every step from minus to plus the span, against a modular model. A design that compared with the wrong bound would step one slot outside the window or wrap one step early. Separate cases hit the window at the very top of the address space, where a bound held in too few bits would overflow and wrap wrongly, and linear wrap in both directions at zero span. A same-cycle write and access checks that the step does not overwrite the written pointer. Bit-reversed accesses check that the stored pointer is not the reversed one.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;

    // Register class selected by the write port
    typedef enum logic [1:0] {
        REG_INDEX  = 2'd0,
        REG_MODIFY = 2'd1,
        REG_LENGTH = 2'd2,
        REG_NONE   = 2'd3
    } reg_cls_e;

endpackage

// File: rtl/cbuf_agen_regs.sv
module cbuf_agen_regs
    import cbuf_agen_pkg::*;
#(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    parameter int NMOD = 4,
    localparam int PW  = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int MW  = (NMOD > 1) ? $clog2(NMOD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          upd_en,
    input  logic [PW-1:0] upd_ptr,
    input  logic [AW-1:0] upd_val,
    input  logic [PW-1:0] rd_ptr,
    input  logic [MW-1:0] rd_mod,
    output logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_step,
    output logic [AW-1:0] rd_len
);

    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] idx;
        logic [NMOD-1:0][AW-1:0] stp;
        logic [NPTR-1:0][AW-1:0] len;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int p = 0; p < NPTR; p++) begin
            if (wr_en && wr_sel == REG_INDEX && wr_idx == PW'(p)) begin
                r_d.idx[p] = wr_data;
            end else if (upd_en && upd_ptr == PW'(p)) begin
                r_d.idx[p] = upd_val;
            end
            if (wr_en && wr_sel == REG_LENGTH && wr_idx == PW'(p)) begin
                r_d.len[p] = wr_data;
            end
        end
        for (int m = 0; m < NMOD; m++) begin
            if (wr_en && wr_sel == REG_MODIFY && wr_idx == PW'(m)) begin
                r_d.stp[m] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_idx  = r_q.idx[rd_ptr];
    assign rd_step = r_q.stp[rd_mod];
    assign rd_len  = r_q.len[rd_ptr];

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr_chk
        // R8
        idx_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == REG_INDEX && wr_idx == PW'(g)) |=> (r_q.idx[g] == $past(wr_data)));
        // R10
        idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_sel == REG_INDEX && wr_idx == PW'(g)) && !(upd_en && upd_ptr == PW'(g)))
            |=> $stable(r_q.idx[g]));
    end

    for (genvar g = 0; g < NMOD; g++) begin : g_mod_chk
        // R9
        step_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == REG_MODIFY && wr_idx == PW'(g)) |=> (r_q.stp[g] == $past(wr_data)));
    end

endmodule

// File: rtl/cbuf_agen_step.sv
module cbuf_agen_step #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);

    logic        [AW-1:0] mask;
    logic        [AW-1:0] base;
    logic        [AW-1:0] raw;
    logic signed [AW+1:0] sum_w;
    logic signed [AW+1:0] lim_w;
    logic signed [AW+1:0] base_w;

    always_comb begin
        // Smear len-1 to get the power-of-two window mask
        mask = len - AW'(1);
        for (int s = 1; s < AW; s = s * 2) begin
            mask = mask | (mask >> s);
        end
        base   = cur & ~mask;
        base_w = $signed({2'b00, base});
        lim_w  = $signed({2'b00, base}) + $signed({2'b00, len});
        sum_w  = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
        raw    = cur + step;
        if (len == '0) begin
            nxt = raw;
        end else if (sum_w >= lim_w) begin
            nxt = raw - len;
        end else if (sum_w < base_w) begin
            nxt = raw + len;
        end else begin
            nxt = raw;
        end
    end

endmodule

// File: rtl/cbuf_agen_brev.sv
module cbuf_agen_brev #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);

    for (genvar b = 0; b < AW; b++) begin : g_bit
        assign dout[b] = din[AW-1-b];
    end

endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen #(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    parameter int NMOD = 4,
    localparam int PW  = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int MW  = (NMOD > 1) ? $clog2(NMOD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic [PW-1:0] acc_ptr,
    input  logic [MW-1:0] acc_mod,
    input  logic          brev_en,
    output logic [AW-1:0] addr_out,
    output logic          addr_vld
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          vld;
    } out_t;

    out_t o_d, o_q;

    logic [AW-1:0] cur_idx, cur_step, cur_len, nxt_idx, rev_idx;

    cbuf_agen_regs #(.AW(AW), .NPTR(NPTR), .NMOD(NMOD)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (acc_en),
        .upd_ptr (acc_ptr),
        .upd_val (nxt_idx),
        .rd_ptr  (acc_ptr),
        .rd_mod  (acc_mod),
        .rd_idx  (cur_idx),
        .rd_step (cur_step),
        .rd_len  (cur_len)
    );

    cbuf_agen_step #(.AW(AW)) u_step (
        .cur  (cur_idx),
        .step (cur_step),
        .len  (cur_len),
        .nxt  (nxt_idx)
    );

    cbuf_agen_brev #(.AW(AW)) u_brev (
        .din  (cur_idx),
        .dout (rev_idx)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = acc_en;
        if (acc_en) begin
            o_d.addr = brev_en ? rev_idx : cur_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign addr_out = o_q.addr;
    assign addr_vld = o_q.vld;

    function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
        return r;
    endfunction

    // R2
    access_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_vld);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (!addr_vld && $stable(addr_out)));
    // R7
    brev_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && brev_en) |=> (addr_out == flip($past(cur_idx))));
    // R2
    plain_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !brev_en) |=> (addr_out == $past(cur_idx)));

endmodule

// File: tb/cbuf_agen_test.sv
module cbuf_agen_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam int AMASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [1:0]    wr_idx = '0;
    logic [AW-1:0] wr_data = '0;
    logic          acc_en = 1'b0;
    logic [1:0]    acc_ptr = '0;
    logic [1:0]    acc_mod = '0;
    logic          brev_en = 1'b0;
    logic [AW-1:0] addr_out;
    logic          addr_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_idx[4];
    int m_stp[4];
    int m_len[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    cbuf_agen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
        .brev_en(brev_en), .addr_out(addr_out), .addr_vld(addr_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int model_next(input int i, input int s, input int l);
        int p2, base, off;
        if (l == 0) return (i + s) & AMASK;
        p2 = 1;
        while (p2 < l) p2 = p2 * 2;
        base = i - (i % p2);
        off  = i - base;
        return base + (((off + s) % l) + l) % l;
    endfunction

    function automatic int rev(input int v);
        int r = 0;
        for (int b = 0; b < AW; b++) if (v[b]) r = r | (1 << (AW-1-b));
        return r;
    endfunction

    // All tasks start and end at a falling edge
    task automatic wr(input int sel, input int idx, input int data);
        wr_en = 1; wr_sel = sel[1:0]; wr_idx = idx[1:0]; wr_data = data[AW-1:0];
        @(negedge clk);
        wr_en = 0;
        if (sel == 0) m_idx[idx] = data & AMASK;
        if (sel == 1) m_stp[idx] = (data & (1 << (AW-1))) ? (data & AMASK) - (1 << AW) : (data & AMASK);
        if (sel == 2) m_len[idx] = data & AMASK;
    endtask

    task automatic acc(input string req, input int p, input int m, input bit br);
        int exp_a;
        acc_en = 1; acc_ptr = p[1:0]; acc_mod = m[1:0]; brev_en = br;
        exp_a = br ? rev(m_idx[p]) : m_idx[p];
        m_idx[p] = model_next(m_idx[p], m_stp[m], m_len[p]);
        @(negedge clk);
        acc_en = 0; brev_en = 0;
        chk("R2 valid", int'(addr_vld), 1);
        chk(req, int'(addr_out), exp_a);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin m_idx[k] = 0; m_stp[k] = 0; m_len[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 addr", int'(addr_out), 0);
        chk("R1 vld", int'(addr_vld), 0);
        rst_n = 1;
        @(negedge clk);
        for (int p = 0; p < 4; p++) acc("R1 pointer zero", p, p, 0);
        for (int p = 0; p < 4; p++) acc("R1 step zero", p, 0, 0);

        // R9: class selection, code 3 writes nothing
        wr(0, 0, 'h0123);
        wr(1, 0, 2);
        wr(3, 0, 'h0777);
        wr(3, 1, 'h0777);
        acc("R9 pointer class", 0, 0, 0);
        acc("R9 code3 ignored", 0, 0, 0);
        chk("R9 next pointer", m_idx[0], 'h0127);

        // R3: linear wrap both ways
        wr(0, 1, 'h3FFE); wr(1, 1, 3);
        acc("R3 linear", 1, 1, 0);
        acc("R3 wrap up", 1, 1, 0);
        wr(0, 1, 1); wr(1, 1, -2 & AMASK);
        acc("R3 linear down", 1, 1, 0);
        acc("R3 wrap down", 1, 1, 0);

        // R4: independent pointers and step selection
        wr(0, 0, 'h10); wr(0, 1, 'h20); wr(0, 2, 'h30); wr(0, 3, 'h40);
        wr(1, 0, 1); wr(1, 1, 5); wr(1, 2, -7 & AMASK); wr(1, 3, 0);
        acc("R4 access", 2, 1, 0);
        for (int p = 0; p < 4; p++) acc("R4 peek", p, 3, 0);
        chk("R4 ptr2 stepped", m_idx[2], 'h35);
        acc("R4 other step", 3, 2, 0);
        acc("R4 peek3", 3, 3, 0);

        // R5/R6: sweep span, start offset and step
        begin
            int cnt = 0;
            for (int l = 1; l <= 12; l++) begin
                for (int off = 0; off < l; off++) begin
                    for (int s = -l; s <= l; s++) begin
                        int p, m;
                        p = cnt % 4; m = cnt % 3; cnt++;
                        wr(0, p, 'h1000 + off);
                        wr(1, m, s & AMASK);
                        wr(2, p, l);
                        acc(s >= 0 ? "R5 fwd" : "R6 back", p, m, 0);
                        acc(s >= 0 ? "R5 fwd" : "R6 back", p, m, 0);
                    end
                end
            end
        end
        // R5: window at the top of the address space
        wr(0, 0, 'h3FFF); wr(1, 0, 1); wr(2, 0, 16);
        acc("R5 top", 0, 0, 0);
        acc("R5 top wrapped", 0, 0, 0);
        chk("R5 top value", m_idx[0], 'h3FF1);
        wr(0, 1, 'h3FF0); wr(1, 1, -3 & AMASK); wr(2, 1, 16);
        acc("R6 top", 1, 1, 0);
        acc("R6 top wrapped", 1, 1, 0);
        for (int k = 0; k < 4; k++) wr(2, k, 0);
        wr(1, 3, 0);

        // R7: bit reverse
        for (int v = 1; v < (1 << AW); v = v * 3 + 1) begin
            wr(0, 2, v); wr(1, 0, 1);
            acc("R7 reversed", 2, 0, 1);
            acc("R7 pointer normal", 2, 3, 0);
        end

        // R8: write beats step on same pointer
        wr(0, 1, 'h0100); wr(1, 1, 1);
        wr_en = 1; wr_sel = 0; wr_idx = 1; wr_data = 'h0AAA;
        acc_en = 1; acc_ptr = 1; acc_mod = 1;
        @(negedge clk);
        wr_en = 0; acc_en = 0;
        chk("R8 old address", int'(addr_out), 'h0100);
        m_idx[1] = 'h0AAA;
        acc("R8 written kept", 1, 3, 0);
        // write to a different pointer: access still steps
        wr(0, 2, 'h0200);
        wr_en = 1; wr_sel = 0; wr_idx = 3; wr_data = 'h0333;
        acc_en = 1; acc_ptr = 2; acc_mod = 1;
        @(negedge clk);
        wr_en = 0; acc_en = 0;
        chk("R8 other addr", int'(addr_out), 'h0200);
        m_idx[2] = 'h0201; m_idx[3] = 'h0333;
        acc("R8 other stepped", 2, 3, 0);
        acc("R8 other written", 3, 3, 0);

        // R10: idle cycles
        repeat (3) @(negedge clk);
        chk("R10 vld low", int'(addr_vld), 0);
        chk("R10 addr held", int'(addr_out), 'h0333);
        for (int p = 0; p < 4; p++) acc("R10 pointer unchanged", p, 3, 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule